// File: doc/BRIEF.md
# Single-Line SPI Master Shift Engine

This block is the bit-level core of a serial flash controller. It drives the serial clock, the single data-out line and one active-low chip select, and it collects the data-in line. Its settings come from a 32-bit configuration word and a separate engine enable. A clock-rate code divides the reference clock by a power of two. Polarity and phase select one of the four usual SPI clocking modes. The chip select can follow the engine or a register bit. An optional manual-start mode holds queued words until software issues a start strobe.

Words arrive on a valid/ready port that stands in for the transmit queue. Each word is 32 bits and is shifted most significant bit first. For every word sent, one received word leaves on a one-cycle valid strobe that stands in for the receive queue. The receive side has no back-pressure.

The control is a three-state machine:
- ST_IDLE: the clock rests at the polarity level.
- ST_SHIFT: 64 clock edges are produced.
- ST_PUSH: the received word is presented.

The transitions are named as follows:
- take_word: ST_IDLE to ST_SHIFT, on a handshake.
- word_done: ST_SHIFT to ST_PUSH, on the 64th edge.
- chain: ST_PUSH to ST_SHIFT, when another word is accepted at once.
- drain: ST_PUSH to ST_IDLE, when the queue is empty.
- abort: ST_SHIFT or ST_PUSH to ST_IDLE, when the engine is disabled.

Top module: `spi_shift_engine`

## Requirements
- R1: While reset is held, `cs_n` is 1 and `sclk`, `mosi` and `rx_valid` are 0 (configuration word all zero).
- R2: Outside a word, `sclk` rests at the polarity bit (configuration bit 1) and follows it one cycle after a change.
- R3: Within a word, successive `sclk` edges are exactly 2^n reference cycles apart, where n is the rate code in configuration bits 5:3. The full clock period is therefore 2<<n cycles.
- R4: `mosi` carries the word most significant bit first, and it is stable at each sampling edge. The sampling edge is the leading edge when the phase bit (bit 2) is 0 and the trailing edge when it is 1.
- R5: Bits on `miso` are captured at the sampling edges, most significant bit first, and exactly one `rx_valid` strobe of one cycle is produced per transmitted word.
- R6: When bit 14 is 0, `cs_n` goes low with an accepted word and stays low across back-to-back words, rising once when the queue empties. When bit 14 is 1, `cs_n` equals bit 10 at all times.
- R7: When bit 15 is 1, no word is accepted until bit 16 is high for a cycle. Words are then sent until `tx_valid` drops, and later words wait for another strobe.
- R8: If `eng_en` or bit 0 is 0, no word is accepted and no clock is produced. Clearing `eng_en` in mid-word returns `sclk` to the polarity level, releases an automatic `cs_n` and drops the word without an `rx_valid`.
- R9: The rate code, polarity and phase are taken when a word is accepted; changing them during a word leaves that word's edge spacing unchanged.
- R10: Every word produces exactly 64 `sclk` transitions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_en | input | 1 | Engine enable |
| cfg_word | input | 32 | Configuration word (bit 0 master, 1 polarity, 2 phase, 5:3 rate code, 10 select level, 14 manual select, 15 manual start, 16 start strobe) |
| tx_data | input | 32 | Word to transmit |
| tx_valid | input | 1 | A transmit word is offered |
| tx_ready | output | 1 | Engine can take a word this cycle |
| rx_data | output | 32 | Received word |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench loops `miso` back inverted and rebuilds each sent word from `mosi` at the edges the phase bit calls for. A design that shifted least significant bit first, or sampled on the wrong edge, returns a shifted or bit-reversed word. Edge spacing is measured in every mode, including the slowest code 7. A design that latched the rate code only at reset, or divided off by one, shows a wrong gap, and a design that read the code live shows a changed gap after a mid-word rewrite. Directed runs cover back-to-back words, the manual-start strobe that must run the queue dry and then stop, and an abort in mid-word. A faulty select would pulse between words, a faulty manual start would keep sending, and a faulty abort would leave the clock stuck or push a partial word.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int DIV_W         = 3;
    localparam int CFG_MASTER    = 0;
    localparam int CFG_CPOL      = 1;
    localparam int CFG_CPHA      = 2;
    localparam int CFG_DIV_LO    = 3;
    localparam int CFG_DIV_HI    = CFG_DIV_LO + DIV_W - 1;
    localparam int CFG_CS_LVL    = 10;
    localparam int CFG_CS_MAN    = 14;
    localparam int CFG_MAN_START = 15;
    localparam int CFG_GO        = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PUSH  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] code,
    output logic             tick
);
    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim_m1;

    assign span   = {{CNT_W{1'b0}}, 1'b1} << code;
    assign lim_m1 = span[CNT_W-1:0] - CNT_W'(1);
    assign tick   = run && (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_cpha,
    input  logic [WORD_W-1:0] load_word,
    input  logic              edge_tick,
    input  logic              lead,
    input  logic              last,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word
);
    logic              cpha_q;
    logic [WORD_W-1:0] tx_sr;
    logic              out_edge;
    logic              in_edge;

    // phase 0: launch on trailing edges, capture on leading ones
    // phase 1: launch on leading edges, capture on trailing ones
    assign out_edge = cpha_q ? lead : (!lead && !last);
    assign in_edge  = cpha_q ? !lead : lead;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpha_q  <= 1'b0;
            tx_sr   <= '0;
            rx_word <= '0;
            mosi    <= 1'b0;
        end else if (load) begin
            cpha_q <= load_cpha;
            if (!load_cpha) begin
                mosi  <= load_word[WORD_W-1];
                tx_sr <= {load_word[WORD_W-2:0], 1'b0};
            end else begin
                tx_sr <= load_word;
            end
        end else if (edge_tick) begin
            if (out_edge) begin
                mosi  <= tx_sr[WORD_W-1];
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            end
            if (in_edge) begin
                rx_word <= {rx_word[WORD_W-2:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_en,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int EDGES = 2 * WORD_W;
    localparam int EC_W  = $clog2(EDGES);

    eng_state_t        state, nxt;
    logic              ena;
    logic              man_start;
    logic              armed;
    logic              can_take;
    logic              accept;
    logic              tick;
    logic              last;
    logic [EC_W-1:0]   edge_cnt;
    logic [DIV_W-1:0]  div_q;
    logic              sclk_q;
    logic [CFG_W-1:0]  cfg_bits_unused;

    assign cfg_bits_unused = cfg_word;
    assign ena       = eng_en && cfg_word[CFG_MASTER];
    assign man_start = cfg_word[CFG_MAN_START];
    assign can_take  = ena && (!man_start || armed) &&
                       (state == ST_IDLE || state == ST_PUSH);
    assign accept    = can_take && tx_valid;
    assign last      = (edge_cnt == EC_W'(EDGES - 1));

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SHIFT),
        .code  (div_q),
        .tick  (tick)
    );

    spi_bit_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_cpha (cfg_word[CFG_CPHA]),
        .load_word (tx_data),
        .edge_tick (tick),
        .lead      (!edge_cnt[0]),
        .last      (last),
        .miso      (miso),
        .mosi      (mosi),
        .rx_word   (rx_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (!ena)              nxt = ST_IDLE;
                else if (tick && last) nxt = ST_PUSH;
            end
            ST_PUSH: begin
                if (!ena)        nxt = ST_IDLE;
                else if (accept) nxt = ST_SHIFT;
                else             nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_ready = can_take;
        rx_valid = (state == ST_PUSH) && ena;
        sclk     = sclk_q;
        if (cfg_word[CFG_CS_MAN]) cs_n = cfg_word[CFG_CS_LVL];
        else                      cs_n = (state == ST_IDLE);
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            div_q    <= '0;
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            if (!ena)
                armed <= 1'b0;
            else if (man_start && cfg_word[CFG_GO])
                armed <= 1'b1;
            else if ((state == ST_IDLE || state == ST_PUSH) && !tx_valid)
                armed <= 1'b0;

            if (accept) begin
                div_q    <= cfg_word[CFG_DIV_HI:CFG_DIV_LO];
                edge_cnt <= '0;
                sclk_q   <= cfg_word[CFG_CPOL];
            end else if (state == ST_IDLE || nxt == ST_IDLE) begin
                sclk_q   <= cfg_word[CFG_CPOL];
            end else if (state == ST_SHIFT && tick) begin
                sclk_q   <= ~sclk_q;
                edge_cnt <= edge_cnt + EC_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk #(
    parameter int WORD_W = 32,
    parameter int CFG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eng_en,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              sclk,
    input logic              cs_n
);
    // R2
    idle_clk_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cs_n) && !$past(cfg_word[14]))
            |-> (sclk == $past(cfg_word[1])));

    // R5
    rx_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8
    disabled_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_en || !cfg_word[0]) |-> !tx_ready);

    // R6
    auto_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !cfg_word[14]) |=> (!cs_n || cfg_word[14]));
endmodule

bind spi_shift_engine spi_shift_engine_chk #(.WORD_W(WORD_W), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_en   (eng_en),
    .cfg_word (cfg_word),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .sclk     (sclk),
    .cs_n     (cs_n)
);

// File: tb/spi_shift_engine_bench.sv
module spi_shift_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        eng_en;
    logic [31:0] cfg_word;
    logic [31:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic        cs_n;

    always #4 clk = ~clk;

    assign miso = ~mosi;

    spi_shift_engine u_spi_shift_engine (
        .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_word(cfg_word),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_err = 0;

    // monitor state
    int          cyc = 0;
    int          edges, gmin, gmax, last_edge, cs_rises;
    bit          have_edge, ready_seen;
    logic        prev_sclk = 1'b0;
    logic        prev_cs = 1'b1;
    logic [31:0] cap;
    logic        m_cpol, m_cpha;
    logic [31:0] rx_log [16];
    int          rx_n = 0;

    // [36] polarity, [35] phase, [34:32] rate code, [31:0] word
    localparam int NV = 6;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 32'hA5C3_0F81},
        {1'b0, 1'b1, 3'd1, 32'h1234_5678},
        {1'b1, 1'b0, 3'd2, 32'hFFFF_0000},
        {1'b1, 1'b1, 3'd0, 32'h8000_0001},
        {1'b0, 1'b0, 3'd3, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 3'd7, 32'h7F00_FF01}
    };

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk !== prev_sclk) begin
            edges = edges + 1;
            if (have_edge) begin
                if (cyc - last_edge < gmin) gmin = cyc - last_edge;
                if (cyc - last_edge > gmax) gmax = cyc - last_edge;
            end
            last_edge = cyc;
            have_edge = 1'b1;
            if ((sclk != m_cpol) == !m_cpha) cap = {cap[30:0], mosi};
        end
        prev_sclk = sclk;
        if (cs_n && !prev_cs) cs_rises = cs_rises + 1;
        prev_cs = cs_n;
        if (tx_ready) ready_seen = 1'b1;
        if (rx_valid) begin
            if (rx_n < 16) rx_log[rx_n] = rx_data;
            rx_n = rx_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_err = n_err + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cfg(input bit master, input bit cpol,
            input bit cpha, input logic [2:0] div, input bit mcs, input bit lvl,
            input bit man, input bit go);
        logic [31:0] c = 32'h8000_00C0;
        c[0] = master; c[1] = cpol; c[2] = cpha; c[5:3] = div;
        c[10] = lvl; c[14] = mcs; c[15] = man; c[16] = go;
        return c;
    endfunction

    task automatic clear_stats();
        edges = 0; gmin = 1 << 30; gmax = 0; have_edge = 1'b0;
        cs_rises = 0; ready_seen = 1'b0; cap = '0;
    endtask

    task automatic setup(input logic [31:0] c);
        cfg_word = c;
        m_cpol = c[1];
        m_cpha = c[2];
        repeat (3) @(negedge clk);
        clear_stats();
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic offer(input logic [31:0] w, input bit keep);
        tx_data  = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        if (!keep) tx_valid = 1'b0;
    endtask

    task automatic wait_rx(input int target);
        int guard = 0;
        while (rx_n < target && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk = n_chk + 1;
        n_err = n_err + 1;
        $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0; eng_en = 1'b0; cfg_word = '0; tx_data = '0; tx_valid = 1'b0;
        m_cpol = 1'b0; m_cpha = 1'b0;
        clear_stats();
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cs_n == 1'b1,   "R1", "cs_n in reset",     {31'd0, cs_n}, 32'd1);
        check(sclk == 1'b0,   "R1", "sclk in reset",     {31'd0, sclk}, 32'd0);
        check(mosi == 1'b0,   "R1", "mosi in reset",     {31'd0, mosi}, 32'd0);
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", {31'd0, rx_valid}, 32'd0);
        rst_n = 1'b1;
        eng_en = 1'b1;
        @(negedge clk);

        // vector table: one word per mode / rate code
        for (int i = 0; i < NV; i++) begin
            logic [31:0] w;
            logic [2:0]  d;
            w = VEC[i][31:0];
            d = VEC[i][34:32];
            setup(mk_cfg(1, VEC[i][36], VEC[i][35], d, 0, 1, 0, 0));
            check(sclk == VEC[i][36], "R2", "idle level", {31'd0, sclk}, {31'd0, VEC[i][36]});
            base = rx_n;
            offer(w, 0);
            wait_rx(base + 1);
            repeat (2) @(negedge clk);
            check(cap == w, "R4", "word seen on mosi", cap, w);
            check(rx_n == base + 1 && rx_log[base] == ~w, "R5", "received word", rx_log[base], ~w);
            check(edges == 64, "R10", "edges per word", edges, 32'd64);
            check(gmin == (1 << d) && gmax == (1 << d), "R3", "edge spacing",
                  gmax, 32'(1 << d));
            check(sclk == VEC[i][36], "R2", "level after word", {31'd0, sclk}, {31'd0, VEC[i][36]});
            check(cs_n == 1'b1, "R6", "select released", {31'd0, cs_n}, 32'd1);
        end

        // R2: idle level follows a polarity change
        cfg_word = mk_cfg(1, 1, 0, 0, 0, 1, 0, 0);
        @(negedge clk);
        check(sclk == 1'b1, "R2", "idle follows polarity", {31'd0, sclk}, 32'd1);

        // R6 back-to-back words keep the select low
        setup(mk_cfg(1, 0, 0, 0, 0, 1, 0, 0));
        base = rx_n;
        offer(32'h1111_0001, 1);
        offer(32'h2222_0002, 1);
        offer(32'h3333_0003, 0);
        wait_rx(base + 3);
        repeat (2) @(negedge clk);
        check(cs_rises == 1, "R6", "select rises once", cs_rises, 32'd1);
        check(rx_n == base + 3, "R5", "one rx per word", rx_n - base, 32'd3);
        check(rx_log[base + 2] == ~32'h3333_0003, "R5", "third word", rx_log[base + 2], ~32'h3333_0003);
        check(edges == 192, "R10", "edges for three words", edges, 32'd192);

        // R6 manual select
        cfg_word = mk_cfg(1, 0, 0, 0, 1, 0, 0, 0);
        @(negedge clk);
        check(cs_n == 1'b0, "R6", "manual select low", {31'd0, cs_n}, 32'd0);
        setup(mk_cfg(1, 0, 0, 0, 1, 1, 0, 0));
        base = rx_n;
        offer(32'h0F0F_0F0F, 0);
        repeat (10) @(negedge clk);
        check(cs_n == 1'b1, "R6", "manual level wins mid-word", {31'd0, cs_n}, 32'd1);
        wait_rx(base + 1);
        repeat (2) @(negedge clk);

        // R7 manual start
        setup(mk_cfg(1, 0, 1, 0, 0, 1, 1, 0));
        base = rx_n;
        tx_data = 32'hCAFE_0001;
        tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        check(!ready_seen && edges == 0 && cs_n, "R7", "holds before strobe",
              {30'd0, ready_seen, cs_n}, 32'd1);
        cfg_word = mk_cfg(1, 0, 1, 0, 0, 1, 1, 1);
        @(negedge clk);
        cfg_word = mk_cfg(1, 0, 1, 0, 0, 1, 1, 0);
        offer(32'hCAFE_0001, 1);
        offer(32'hCAFE_0002, 0);
        wait_rx(base + 2);
        repeat (2) @(negedge clk);
        check(rx_n == base + 2 && rx_log[base + 1] == ~32'hCAFE_0002, "R7", "queue sent",
              rx_log[base + 1], ~32'hCAFE_0002);
        check(cs_rises == 1, "R7", "one burst", cs_rises, 32'd1);
        tx_data = 32'hCAFE_0003;
        tx_valid = 1'b1;
        repeat (30) @(negedge clk);
        check(rx_n == base + 2 && cs_n == 1'b1, "R7", "waits for next strobe", rx_n - base, 32'd2);
        cfg_word = mk_cfg(1, 0, 1, 0, 0, 1, 1, 1);
        @(negedge clk);
        cfg_word = mk_cfg(1, 0, 1, 0, 0, 1, 1, 0);
        offer(32'hCAFE_0003, 0);
        wait_rx(base + 3);
        check(rx_log[base + 2] == ~32'hCAFE_0003, "R7", "after second strobe",
              rx_log[base + 2], ~32'hCAFE_0003);
        repeat (2) @(negedge clk);

        // R8 disabled: master bit clear, then enable low
        setup(mk_cfg(0, 1, 0, 0, 0, 1, 0, 0));
        base = rx_n;
        tx_data = 32'h5555_AAAA;
        tx_valid = 1'b1;
        repeat (30) @(negedge clk);
        check(!ready_seen && edges == 0 && cs_n && sclk, "R8", "master bit clear",
              {30'd0, ready_seen, sclk}, 32'd1);
        cfg_word = mk_cfg(1, 1, 0, 0, 0, 1, 0, 0);
        eng_en = 1'b0;
        clear_stats();
        repeat (30) @(negedge clk);
        check(!ready_seen && edges == 0 && rx_n == base, "R8", "engine disabled",
              {31'd0, ready_seen}, 32'd0);
        tx_valid = 1'b0;
        eng_en = 1'b1;

        // R8 abort in mid-word
        setup(mk_cfg(1, 1, 0, 2, 0, 1, 0, 0));
        base = rx_n;
        offer(32'h1357_9BDF, 0);
        repeat (40) @(negedge clk);
        eng_en = 1'b0;
        repeat (2) @(negedge clk);
        check(sclk == 1'b1 && cs_n == 1'b1, "R8", "abort returns to idle",
              {30'd0, sclk, cs_n}, 32'd3);
        repeat (300) @(negedge clk);
        check(rx_n == base, "R8", "aborted word not pushed", rx_n - base, 32'd0);
        eng_en = 1'b1;
        setup(mk_cfg(1, 1, 0, 0, 0, 1, 0, 0));
        base = rx_n;
        offer(32'h2468_ACE0, 0);
        wait_rx(base + 1);
        check(rx_log[base] == ~32'h2468_ACE0, "R8", "word after abort", rx_log[base], ~32'h2468_ACE0);
        repeat (2) @(negedge clk);

        // R9 settings held during a word
        setup(mk_cfg(1, 0, 0, 0, 0, 1, 0, 0));
        base = rx_n;
        offer(32'h0000_FFFF, 0);
        repeat (10) @(negedge clk);
        cfg_word = mk_cfg(1, 0, 0, 3, 0, 1, 0, 0);
        wait_rx(base + 1);
        check(gmin == 1 && gmax == 1, "R9", "spacing kept in word", gmax, 32'd1);
        check(rx_log[base] == ~32'h0000_FFFF, "R9", "word intact", rx_log[base], ~32'h0000_FFFF);
        repeat (2) @(negedge clk);
        clear_stats();
        offer(32'hFFFF_0000, 0);
        wait_rx(base + 2);
        check(gmin == 8 && gmax == 8, "R9", "new code on next word", gmax, 32'd8);

        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule